// File: doc/BRIEF.md
# PWM Output Steering Controller

This block produces one PWM waveform from its own period/duty counter and routes it onto any subset of four output pins. A pin whose steering bit is set carries the waveform; a pin whose bit is clear carries a general-purpose port data bit. Each pin also passes through a direction control: a pin set as an input is not driven, and its output enable is low.

Software writes four 8-bit registers over a simple write strobe: the period, the duty, the steering mask and a mode register. The mode register holds the capture/compare mode bits, the output-mode field and a synchronization bit.

With the synchronization bit clear, a new steering mask takes effect on the next cycle. This can cut a pulse short, which is useful when the PWM must be removed from a pin at once. With the bit set, a new mask waits until the period restarts, so every pin always carries whole PWM pulses. Steering only applies when the mode register selects single-output PWM. In every other mode, all pins carry port data.

Top module: `pwm_steer_top`

## Requirements
- R1: After reset, the period, duty and mode registers are 0, the synchronization bit is 0, and the active and pending steering masks are both 4'b0001. Because mode 0 is not single-output PWM, every enabled pin carries its port data bit.
- R2: The counter steps from 0 up to the period value (address 0) and returns to 0 on the cycle after it reaches or exceeds the period. The waveform is high while the counter is below the duty value (address 1).
- R3: In single-output PWM mode, pin i carries the waveform when active mask bit i is 1, and port_data[i] when it is 0. The mask occupies bits [3:0] of address 2, with bit 0 steering pin A.
- R4: Single-output PWM mode holds only when mode register (address 3) bits [5:4] equal 2'b00 and bits [3:2] equal 2'b11. In every other mode, all pins carry port data.
- R5: When synchronization bit 6 of address 3 is 0, a mask written to address 2 is active from the next cycle. This holds even in the middle of a pulse.
- R6: When the synchronization bit is 1, a written mask is held pending and becomes active in the cycle in which the counter returns to 0. Until then, the previous mask stays active.
- R7: In synchronization mode, a second mask write before the period boundary replaces the pending mask. Only the latest value is applied.
- R8: Writing the mode register with bit 6 = 0 while synchronization is on and a mask is pending makes the pending mask active on the next cycle.
- R9: A pin with pin_dir bit = 1 (input) has pin_oe = 0 and pin_out = 0. A pin with pin_dir = 0 has pin_oe = 1.
- R10: With an active mask of all zeros, no pin carries the waveform, and every pin shows its port data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty, 2 steering mask, 3 mode |
| wr_data | input | 8 | Write data |
| port_data | input | 4 | General-purpose data per pin |
| pin_dir | input | 4 | Direction per pin, 1 = input (not driven) |
| pin_out | output | 4 | Pin drive value |
| pin_oe | output | 4 | Pin output enable |

## Verification
The bound checker watches several rules on every cycle:
- the counter returns to 0 after it reaches the period;
- an immediate mask write reaches the active mask on the next cycle;
- in synchronization mode, the active mask stays fixed between period boundaries;
- the pending mask always holds the latest write;
- leaving synchronization mode promotes the pending mask;
- input pins are never driven;
- outside single-output PWM mode, the pins show port data.

The bench shows the waveform shape, as seen on a pin, against a phase it finds from a rising edge of that pin. It also shows the exact cycle in which a pending mask appears on the pins after writes placed mid-period, and the static routing over a table of mask, mode, port and direction patterns.

// File: rtl/pwm_steer_pkg.sv
// Shared register map and mode decode for the PWM steering controller.
// Assumes an 8-bit write data bus and a 2-bit register address.
package pwm_steer_pkg;
    localparam logic [1:0] ADDR_PERIOD = 2'd0;
    localparam logic [1:0] ADDR_DUTY   = 2'd1;
    localparam logic [1:0] ADDR_STEER  = 2'd2;
    localparam logic [1:0] ADDR_MODE   = 2'd3;
    localparam int         SYNC_BIT    = 6;

    // True when the mode fields select single-output PWM.
    function automatic logic is_single(input logic [1:0] out_mode, input logic [3:0] ccp_mode);
        return (out_mode == 2'b00) && (ccp_mode[3:2] == 2'b11);
    endfunction
endpackage

// File: rtl/pwm_steer_timebase.sv
// Period/duty PWM generator. Holds the period and duty registers, runs a counter
// from 0 to the period, and flags the last cycle of each period (wrap).
// Assumes the register writes come from a single-cycle strobe.
module pwm_steer_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_wr,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] period_q,
    output logic             wrap,
    output logic             pwm
);
    logic [CNT_W-1:0] duty_q;

    // Period and duty register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            duty_q   <= '0;
        end else begin
            if (period_wr) period_q <= wr_val;
            if (duty_wr)   duty_q   <= wr_val;
        end
    end

    // Free-running counter that restarts after reaching the period.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (wrap) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    // Wrap flag and waveform from the counter state.
    always_comb begin
        wrap = (cnt >= period_q);
        pwm  = (cnt < duty_q);
    end
endmodule

// File: rtl/pwm_steer_mask_ctl.sv
// Steering mask control: mode register, active mask, pending mask and the
// immediate or period-aligned update policy. Assumes wrap marks the last
// cycle of a PWM period, so a mask applied at that edge starts a full period.
module pwm_steer_mask_ctl
    import pwm_steer_pkg::*;
#(
    parameter int NPIN   = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              steer_wr,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wrap,
    output logic [NPIN-1:0]   active_mask,
    output logic [NPIN-1:0]   pending_mask,
    output logic              pend_flag,
    output logic              sync_mode,
    output logic              single_mode
);
    localparam logic [NPIN-1:0] RST_MASK = {{(NPIN-1){1'b0}}, 1'b1};

    logic [3:0] ccp_mode;
    logic [1:0] out_mode;
    logic       desync;
    logic       unused_bits;

    assign unused_bits = ^wr_data[DATA_W-1:SYNC_BIT+1];
    assign desync      = mode_wr && sync_mode && pend_flag && !wr_data[SYNC_BIT];

    // Mode register: capture/compare bits, output-mode field, sync bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccp_mode  <= '0;
            out_mode  <= '0;
            sync_mode <= 1'b0;
        end else if (mode_wr) begin
            ccp_mode  <= wr_data[3:0];
            out_mode  <= wr_data[5:4];
            sync_mode <= wr_data[SYNC_BIT];
        end
    end

    // Active/pending mask update: immediate, desync promote, or at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_mask  <= RST_MASK;
            pending_mask <= RST_MASK;
            pend_flag    <= 1'b0;
        end else if (steer_wr) begin
            pending_mask <= wr_data[NPIN-1:0];
            if (sync_mode) begin
                pend_flag <= 1'b1;
            end else begin
                active_mask <= wr_data[NPIN-1:0];
                pend_flag   <= 1'b0;
            end
        end else if (desync || (wrap && pend_flag)) begin
            active_mask <= pending_mask;
            pend_flag   <= 1'b0;
        end
    end

    // Single-output PWM qualification.
    always_comb single_mode = is_single(out_mode, ccp_mode);
endmodule

// File: rtl/pwm_steer_pin.sv
// One output pin: selects the waveform or port data, then gates the result
// with the direction control. Assumes dir_in = 1 means the pin is an input.
module pwm_steer_pin (
    input  logic pwm,
    input  logic steer_en,
    input  logic single_mode,
    input  logic port_bit,
    input  logic dir_in,
    output logic pin,
    output logic oe
);
    // Source select and direction gating.
    always_comb begin
        oe  = !dir_in;
        pin = oe & ((single_mode && steer_en) ? pwm : port_bit);
    end
endmodule

// File: rtl/pwm_steer_top.sv
// PWM output steering controller top: write decode, PWM timebase, mask
// control and one pin stage per steerable output.
module pwm_steer_top
    import pwm_steer_pkg::*;
#(
    parameter int NPIN   = 4,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NPIN-1:0]   port_data,
    input  logic [NPIN-1:0]   pin_dir,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period_q;
    logic             wrap;
    logic             pwm_wave;
    logic [NPIN-1:0]  active_mask;
    logic [NPIN-1:0]  pending_mask;
    logic             pend_flag;
    logic             sync_mode;
    logic             single_mode;
    logic             unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:CNT_W-1];

    pwm_steer_timebase #(.CNT_W(CNT_W)) i_timebase (
        .clk(clk), .rst_n(rst_n),
        .period_wr(wr_en && wr_addr == ADDR_PERIOD),
        .duty_wr(wr_en && wr_addr == ADDR_DUTY),
        .wr_val(wr_data[CNT_W-1:0]),
        .cnt(cnt), .period_q(period_q), .wrap(wrap), .pwm(pwm_wave)
    );

    pwm_steer_mask_ctl #(.NPIN(NPIN), .DATA_W(DATA_W)) i_mask_ctl (
        .clk(clk), .rst_n(rst_n),
        .steer_wr(wr_en && wr_addr == ADDR_STEER),
        .mode_wr(wr_en && wr_addr == ADDR_MODE),
        .wr_data(wr_data), .wrap(wrap),
        .active_mask(active_mask), .pending_mask(pending_mask),
        .pend_flag(pend_flag), .sync_mode(sync_mode), .single_mode(single_mode)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pwm_steer_pin i_pin (
            .pwm(pwm_wave), .steer_en(active_mask[i]), .single_mode(single_mode),
            .port_bit(port_data[i]), .dir_in(pin_dir[i]),
            .pin(pin_out[i]), .oe(pin_oe[i])
        );
    end
endmodule

// File: rtl/pwm_steer_checker.sv
// Assertion checker for pwm_steer_top, attached by bind below.
module pwm_steer_checker #(
    parameter int NPIN  = 4,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [6:0]       wr_low,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period_q,
    input logic             wrap,
    input logic [NPIN-1:0]  active_mask,
    input logic [NPIN-1:0]  pending_mask,
    input logic             pend_flag,
    input logic             sync_mode,
    input logic             single_mode,
    input logic [NPIN-1:0]  port_data,
    input logic [NPIN-1:0]  pin_dir,
    input logic [NPIN-1:0]  pin_out,
    input logic [NPIN-1:0]  pin_oe
);
    AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (active_mask == NPIN'(1) && pending_mask == NPIN'(1) && !sync_mode)); // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= period_q) |=> (cnt == '0)); // R2
    AST_IMM_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && !sync_mode) |=> (active_mask == $past(wr_low[NPIN-1:0]))); // R5
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !wrap && !(wr_en && wr_addr == 2'd3)) |=> $stable(active_mask)); // R6
    AST_PEND_LATEST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && sync_mode) |=> (pending_mask == $past(wr_low[NPIN-1:0]) && pend_flag)); // R7
    AST_DESYNC_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && pend_flag && wr_en && wr_addr == 2'd3 && !wr_low[6]) |=> (active_mask == $past(pending_mask))); // R8
    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & pin_dir) == '0) && ((pin_out & pin_dir) == '0)); // R9
    AST_NONSINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !single_mode |-> (pin_out == (port_data & ~pin_dir))); // R4
endmodule

bind pwm_steer_top pwm_steer_checker #(.NPIN(NPIN), .CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_low(wr_data[6:0]),
    .cnt(cnt), .period_q(period_q), .wrap(wrap), .active_mask(active_mask),
    .pending_mask(pending_mask), .pend_flag(pend_flag), .sync_mode(sync_mode),
    .single_mode(single_mode), .port_data(port_data), .pin_dir(pin_dir),
    .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_pwm_steer_top.sv
module test_pwm_steer_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] port_data = '0;
    logic [3:0] pin_dir = '0;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_steer_top i_pwm_steer_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .port_data(port_data), .pin_dir(pin_dir), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Row: {req[3:0], addr[1:0], data[7:0], port[3:0], dir[3:0], exp_out[3:0], exp_oe[3:0]}
    // The waveform is held constantly high (period 3, duty 255) while the table runs.
    localparam logic [29:0] VEC [8] = '{
        {4'd3,  2'd2, 8'h01, 4'b0000, 4'b0000, 4'b0001, 4'b1111}, // R3 steer A only
        {4'd3,  2'd2, 8'h06, 4'b1001, 4'b0000, 4'b1111, 4'b1111}, // R3 B,C steered, A,D port
        {4'd10, 2'd2, 8'h00, 4'b0101, 4'b0000, 4'b0101, 4'b1111}, // R10 empty mask
        {4'd9,  2'd2, 8'h0A, 4'b0000, 4'b0011, 4'b1000, 4'b1100}, // R9 B input, D driven
        {4'd4,  2'd3, 8'h1C, 4'b0110, 4'b0000, 4'b0110, 4'b1111}, // R4 output mode 01
        {4'd4,  2'd3, 8'h08, 4'b0001, 4'b0000, 4'b0001, 4'b1111}, // R4 ccp[3:2]=10
        {4'd4,  2'd3, 8'h0C, 4'b0001, 4'b0000, 4'b1011, 4'b1111}, // R4 single again
        {4'd9,  2'd2, 8'h0F, 4'b0000, 4'b1111, 4'b0000, 4'b0000}  // R9 all inputs
    };

    task automatic check(input string req, input logic [3:0] exp_out, input logic [3:0] exp_oe);
        checks++;
        if (pin_out !== exp_out || pin_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s: pin_out=%b pin_oe=%b expected pin_out=%b pin_oe=%b",
                     req, pin_out, pin_oe, exp_out, exp_oe);
        end
    endtask

    // Drive one register write at the current falling edge; return one cycle later.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Wait until pin A rises, which marks the cycle where the counter is 0.
    task automatic align();
        logic prev;
        prev = pin_out[0];
        forever begin
            @(negedge clk);
            if (!prev && pin_out[0]) break;
            prev = pin_out[0];
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        port_data = 4'b1010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset mode shows port data", 4'b1010, 4'b1111);

        port_data = 4'b0000;
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd255);
        wr(2'd3, 8'h0C);
        check("R1 reset mask steers pin A", 4'b0001, 4'b1111);

        for (int i = 0; i < 8; i++) begin
            port_data = VEC[i][15:12];
            pin_dir   = VEC[i][11:8];
            wr(VEC[i][25:24], VEC[i][23:16]);
            checks++;
            if (pin_out !== VEC[i][7:4] || pin_oe !== VEC[i][3:0]) begin
                errors++;
                $display("FAIL R%0d row %0d: pin_out=%b pin_oe=%b expected pin_out=%b pin_oe=%b",
                         VEC[i][29:26], i, pin_out, pin_oe, VEC[i][7:4], VEC[i][3:0]);
            end
        end

        // R2: waveform shape with period 3 and duty 2 -> high, high, low, low.
        pin_dir = 4'b0000; port_data = 4'b0000;
        wr(2'd2, 8'h01);
        wr(2'd1, 8'd2);
        align();
        for (int k = 0; k < 8; k++) begin
            check("R2 waveform", {3'b000, ((k % 4) < 2)}, 4'b1111);
            @(negedge clk);
        end

        // R5: immediate write mid-pulse cuts pin A and moves the waveform to pin C.
        wr(2'd1, 8'd3);
        align();                      // counter 0, pin A high
        wr(2'd2, 8'h04);              // counter now 1, mid-pulse
        check("R5 immediate switch mid-pulse", 4'b0100, 4'b1111);
        wr(2'd2, 8'h01);
        align();                      // counter 0
        wr(2'd3, 8'h4C);              // counter 1, sync mode on
        wr(2'd2, 8'h02);              // counter 2, B pending
        check("R6 old mask held mid-period", 4'b0001, 4'b1111);
        wr(2'd2, 8'h04);              // counter 3, C replaces B
        check("R6 low phase before boundary", 4'b0000, 4'b1111);
        @(negedge clk);               // counter 0
        check("R7 latest pending mask applied at boundary", 4'b0100, 4'b1111);
        wr(2'd2, 8'h08);              // counter 1, D pending
        check("R6 pending mask not yet active", 4'b0100, 4'b1111);
        wr(2'd3, 8'h0C);              // counter 2, sync off promotes pending
        check("R8 pending promoted on leaving sync mode", 4'b1000, 4'b1111);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule